// File: doc/BRIEF.md
# PTE accessed/dirty updater

This block sits at the end of a page-table walk, at the point where a leaf entry has been found. It looks at the entry's accessed (A) and dirty (D) bits together with the kind of access that started the walk, and decides whether the entry must change before the translation can be used. When hardware updating is switched on for the translation stage in use, it performs a locked read of the entry from memory. It compares what it reads with the value the walker saw. If the two match, it writes back the entry with A set, and with D set too for a store. If they differ, it tells the walker to restart the walk from its first level.

When hardware updating is switched off, a missing A bit, or a missing D bit on a store, becomes a page fault of the original access kind. The walker presents one request at a time on a valid/ready pair. A single-cycle `done` pulse returns the result, flagged as a plain completion, a restart request or a fault with its exception code. The walker also supplies the result of the physical-memory-attribute and protection check for writing the entry. It also says whether the access is still speculative.

Top module: `pte_ad_updater`

## Requirements
- R1: If A (bit 6) is set, and either the access is not a store or D (bit 7) is set, the result is `done` on the cycle after acceptance, with no memory request, no fault, no retry, and `pte_out` equal to the entry presented.
- R2: Access kind is encoded on `req_acc` as 0 load, 1 store, 2 fetch. Stage is encoded on `req_stage` as 0 single-stage, 1 guest-stage, 2 VS-stage. Stages 0 and 1 are enabled by `m_upd_en` (bit 61 of the machine environment configuration register) alone. Stage 2 is enabled only when `h_upd_en` (bit 61 of the hypervisor environment configuration register) and `m_upd_en` are both 1.
- R3: When an update is needed, enabled and allowed, the block issues a read of `req_paddr`. If the data returned equals the presented entry, it then issues a write of the entry with bit 6 set, and bit 7 also set for a store. `done` follows the write acknowledge, with `pte_out` equal to the written value.
- R4: If the locked read returns a value different from the presented entry, the block issues no write and ends with `done` and `retry` both set.
- R5: `mem_lock` is high on every cycle on which `mem_req` is high. It drops only on the cycle on which `done` rises, and `mem_addr` holds steady while a request is pending.
- R6: With updating disabled for the stage, an entry needing an update faults with `fault_code` 13 for a load, 15 for a store and 12 for a fetch, and the block makes no memory request.
- R7: With updating enabled but `pte_wr_ok` low, an entry needing an update faults with `fault_code` 5 for a load, 7 for a store and 1 for a fetch, and memory is not touched.
- R8: A speculative store (`req_spec` high) that needs D set ends with `retry` and makes no memory request. A speculative access that needs only A set is updated normally.
- R9: `req_ready` is high only while no request is in progress. `retry` and `fault_vld` are each only high together with `done`, and never both at once.
- R10: After reset, `req_ready` is high, and `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walker presents a leaf entry |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_pte | input | PTE_W | Leaf entry value seen by the walker |
| req_paddr | input | PA_W | Physical address of the entry |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_stage | input | 2 | Translation stage: 0 single, 1 guest, 2 VS |
| req_spec | input | 1 | Access is still speculative |
| m_upd_en | input | 1 | Machine-level hardware update enable |
| h_upd_en | input | 1 | Hypervisor-level update enable for VS-stage |
| pte_wr_ok | input | 1 | Attribute/protection check permits writing the entry |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_lock | output | 1 | Keeps other requesters off between read and write |
| mem_addr | output | PA_W | Memory address |
| mem_wdata | output | PTE_W | Write data |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | PTE_W | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| retry | output | 1 | Walker must restart from the first level |
| fault_vld | output | 1 | Completion is an exception |
| fault_code | output | 4 | Exception code when `fault_vld` is high |
| pte_out | output | PTE_W | Final entry value on a successful completion |

## Verification
The hardest case to reach from the ports is a failed compare in the locked read. The walker's copy and the memory copy must disagree at the moment the read returns. The bench gets there by loading its memory model with a value that differs from the presented entry in a bit the block does not modify. It then confirms that no write follows and that memory still holds that value. Memory latency is varied from zero to several cycles, so that the lock and address hold across both transactions are observed over long waits as well as in back-to-back acknowledges.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

    localparam int unsigned A_POS = 6;
    localparam int unsigned D_POS = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        STG_SINGLE = 2'd0,
        STG_GUEST  = 2'd1,
        STG_VS     = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        OC_NONE         = 3'd0,
        OC_PAGE_FAULT   = 3'd1,
        OC_ACCESS_FAULT = 3'd2,
        OC_RETRY        = 3'd3,
        OC_MEM          = 3'd4
    } outcome_e;

    function automatic logic [3:0] page_fault_code(input logic [1:0] acc);
        case (acc)
            ACC_STORE: page_fault_code = 4'd15;
            ACC_FETCH: page_fault_code = 4'd12;
            default:   page_fault_code = 4'd13;
        endcase
    endfunction

    function automatic logic [3:0] access_fault_code(input logic [1:0] acc);
        case (acc)
            ACC_STORE: access_fault_code = 4'd7;
            ACC_FETCH: access_fault_code = 4'd1;
            default:   access_fault_code = 4'd5;
        endcase
    endfunction

endpackage

// File: rtl/pte_ad_check.sv
module pte_ad_check
    import pte_ad_pkg::*;
(
    input  logic       a_set,
    input  logic       d_set,
    input  logic [1:0] acc,
    input  logic [1:0] stage,
    input  logic       spec,
    input  logic       m_en,
    input  logic       h_en,
    input  logic       wr_ok,
    output outcome_e   outcome,
    output logic [3:0] fcode
);
    logic is_store;
    logic need_a;
    logic need_d;
    logic stage_en;

    assign is_store = (acc == ACC_STORE);
    assign need_a   = !a_set;
    assign need_d   = is_store && !d_set;
    // the hypervisor enable only counts while the machine enable is set
    assign stage_en = (stage == STG_VS) ? (m_en && h_en) : m_en;

    always_comb begin
        outcome = OC_NONE;
        fcode   = 4'd0;
        if (!(need_a || need_d)) begin
            outcome = OC_NONE;
        end else if (!stage_en) begin
            outcome = OC_PAGE_FAULT;
            fcode   = page_fault_code(acc);
        end else if (!wr_ok) begin
            outcome = OC_ACCESS_FAULT;
            fcode   = access_fault_code(acc);
        end else if (spec && need_d) begin
            // dirty marking must wait until the store is certain
            outcome = OC_RETRY;
        end else begin
            outcome = OC_MEM;
        end
    end
endmodule

// File: rtl/pte_ad_merge.sv
module pte_ad_merge
    import pte_ad_pkg::*;
#(
    parameter int unsigned PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_store,
    output logic [PTE_W-1:0] pte_new
);
    always_comb begin
        pte_new        = pte_in;
        pte_new[A_POS] = 1'b1;
        if (is_store) begin
            pte_new[D_POS] = 1'b1;
        end
    end
endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
    import pte_ad_pkg::*;
#(
    parameter int unsigned PTE_W = 64,
    parameter int unsigned PA_W  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PTE_W-1:0] req_pte,
    input  logic [PA_W-1:0]  req_paddr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_stage,
    input  logic             req_spec,
    input  logic             m_upd_en,
    input  logic             h_upd_en,
    input  logic             pte_wr_ok,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             done,
    output logic             retry,
    output logic             fault_vld,
    output logic [3:0]       fault_code,
    output logic [PTE_W-1:0] pte_out
);
    typedef struct packed {
        state_e           st;
        logic [PTE_W-1:0] seen;
        logic [PTE_W-1:0] upd;
        logic [PA_W-1:0]  addr;
        logic             done;
        logic             retry;
        logic             fvld;
        logic [3:0]       fcode;
        logic [PTE_W-1:0] pout;
    } regs_t;

    regs_t    r_q;
    regs_t    r_d;
    outcome_e chk_outcome;
    logic [3:0] chk_fcode;
    logic [PTE_W-1:0] merged_pte;

    pte_ad_check u_check (
        .a_set   (req_pte[A_POS]),
        .d_set   (req_pte[D_POS]),
        .acc     (req_acc),
        .stage   (req_stage),
        .spec    (req_spec),
        .m_en    (m_upd_en),
        .h_en    (h_upd_en),
        .wr_ok   (pte_wr_ok),
        .outcome (chk_outcome),
        .fcode   (chk_fcode)
    );

    pte_ad_merge #(.PTE_W(PTE_W)) u_merge (
        .pte_in   (req_pte),
        .is_store (req_acc == ACC_STORE),
        .pte_new  (merged_pte)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.retry = 1'b0;
        r_d.fvld  = 1'b0;
        r_d.fcode = 4'd0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.seen = req_pte;
                    r_d.upd  = merged_pte;
                    r_d.addr = req_paddr;
                    case (chk_outcome)
                        OC_NONE: begin
                            r_d.done = 1'b1;
                            r_d.pout = req_pte;
                        end
                        OC_PAGE_FAULT, OC_ACCESS_FAULT: begin
                            r_d.done  = 1'b1;
                            r_d.fvld  = 1'b1;
                            r_d.fcode = chk_fcode;
                        end
                        OC_RETRY: begin
                            r_d.done  = 1'b1;
                            r_d.retry = 1'b1;
                        end
                        default: begin
                            r_d.st = ST_READ;
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (mem_rdata == r_q.seen) begin
                        r_d.st = ST_WRITE;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.retry = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pout = r_q.upd;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_req    = (r_q.st != ST_IDLE);
    assign mem_we     = (r_q.st == ST_WRITE);
    assign mem_lock   = (r_q.st != ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.upd;
    assign done       = r_q.done;
    assign retry      = r_q.retry;
    assign fault_vld  = r_q.fvld;
    assign fault_code = r_q.fcode;
    assign pte_out    = r_q.pout;
endmodule

// File: rtl/pte_ad_updater_chk.sv
module pte_ad_updater_chk #(
    parameter int unsigned PA_W = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_lock,
    input logic            mem_ack,
    input logic [PA_W-1:0] mem_addr,
    input logic            wr_a,
    input logic            done,
    input logic            retry,
    input logic            fault_vld
);
    logic rd_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_seen_q <= 1'b0;
        end else if (mem_req && !mem_we && mem_ack) begin
            rd_seen_q <= 1'b1;
        end else if (done) begin
            rd_seen_q <= 1'b0;
        end
    end

    AST_LOCK_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> done); // R5
    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R5
    AST_WRITE_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> wr_a); // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> rd_seen_q); // R4
    AST_RETRY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> done); // R9
    AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (done && !retry)); // R9
    AST_QUIET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R9
endmodule

bind pte_ad_updater pte_ad_updater_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .wr_a      (mem_wdata[pte_ad_pkg::A_POS]),
    .done      (done),
    .retry     (retry),
    .fault_vld (fault_vld)
);

// File: tb/sim_pte_ad_updater.sv
`timescale 1ns/1ps
module sim_pte_ad_updater;
    localparam int PTE_W = 64;
    localparam int PA_W  = 56;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PTE_W-1:0] req_pte = '0;
    logic [PA_W-1:0]  req_paddr = '0;
    logic [1:0]       req_acc = 2'd0;
    logic [1:0]       req_stage = 2'd0;
    logic             req_spec = 1'b0;
    logic             m_upd_en = 1'b0;
    logic             h_upd_en = 1'b0;
    logic             pte_wr_ok = 1'b0;
    logic             mem_req, mem_we, mem_lock, mem_ack;
    logic [PA_W-1:0]  mem_addr;
    logic [PTE_W-1:0] mem_wdata, mem_rdata;
    logic             done, retry, fault_vld;
    logic [3:0]       fault_code;
    logic [PTE_W-1:0] pte_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural memory: 16 doublewords, fixed per-run latency
    logic [63:0] bmem [16];
    int lat = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;

    pte_ad_updater #(.PTE_W(PTE_W), .PA_W(PA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pte(req_pte), .req_paddr(req_paddr), .req_acc(req_acc),
        .req_stage(req_stage), .req_spec(req_spec), .m_upd_en(m_upd_en),
        .h_upd_en(h_upd_en), .pte_wr_ok(pte_wr_ok), .mem_req(mem_req),
        .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .retry(retry), .fault_vld(fault_vld),
        .fault_code(fault_code), .pte_out(pte_out)
    );

    assign mem_ack   = mem_req && (wcnt == lat);
    assign mem_rdata = bmem[mem_addr[6:3]];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_ack) begin
                if (mem_we) begin
                    bmem[mem_addr[6:3]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic finish_sim();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run did not finish (act=%0d exp<=100000 cycles)", cyc);
            finish_sim();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // one request through the reference model; memory holds memval at idx
    task automatic run(input string tag, input logic [63:0] pte, input int idx,
                       input logic [1:0] acc, input logic [1:0] stg, input bit spec,
                       input bit men, input bit hen, input bit wok, input int l,
                       input logic [63:0] memval);
        bit needa, needd, en, match;
        int kind;      // 0 clean, 1 page fault, 2 access fault, 3 retry, 4 memory path
        int expn;
        logic [3:0] efc;
        logic [63:0] npte, emem;
        int rd0, wr0;
        needa = !pte[6];
        needd = (acc == 2'd1) && !pte[7];
        en    = (stg == 2'd2) ? (men && hen) : men;
        npte  = pte | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
        match = (memval == pte);
        efc   = 4'd0;
        if (!(needa || needd)) kind = 0;
        else if (!en) begin
            kind = 1;
            efc = (acc == 2'd1) ? 4'd15 : (acc == 2'd2) ? 4'd12 : 4'd13;
        end else if (!wok) begin
            kind = 2;
            efc = (acc == 2'd1) ? 4'd7 : (acc == 2'd2) ? 4'd1 : 4'd5;
        end else if (spec && needd) kind = 3;
        else kind = 4;
        if (kind != 4) expn = 1;
        else if (!match) expn = l + 2;
        else expn = 2 * l + 3;
        emem = (kind == 4 && match) ? npte : memval;

        bmem[idx] = memval;
        lat = l;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        chk(req_ready == 1'b1, "R9", {tag, " ready before request"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_pte   = pte;
        req_paddr = PA_W'(idx * 8 + 56'h8000);
        req_acc   = acc;
        req_stage = stg;
        req_spec  = spec;
        m_upd_en  = men;
        h_upd_en  = hen;
        pte_wr_ok = wok;
        for (int n = 1; n <= expn; n++) begin
            bit ereq, ewe;
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            ereq = (kind == 4) && (n < expn);
            ewe  = (kind == 4) && match && (n > l + 1) && (n < expn);
            chk(done == (n == expn), tag, "done timing", 64'(done), 64'(n == expn));
            chk(mem_req == ereq && mem_we == ewe, tag, "memory request timing",
                {62'd0, mem_req, mem_we}, {62'd0, ereq, ewe});
            if (mem_req)
                chk(mem_lock == 1'b1, "R5", {tag, " lock held"}, 64'(mem_lock), 64'd1);
        end
        chk(retry == (kind == 3 || (kind == 4 && !match)), tag, "retry",
            64'(retry), 64'(kind == 3 || (kind == 4 && !match)));
        chk(fault_vld == (kind == 1 || kind == 2), tag, "fault_vld",
            64'(fault_vld), 64'(kind == 1 || kind == 2));
        if (kind == 1 || kind == 2)
            chk(fault_code == efc, tag, "fault_code", 64'(fault_code), 64'(efc));
        if (kind == 0)
            chk(pte_out == pte, tag, "pte_out unchanged", pte_out, pte);
        if (kind == 4 && match)
            chk(pte_out == npte, tag, "pte_out updated", pte_out, npte);
        chk(bmem[idx] == emem, tag, "memory contents", bmem[idx], emem);
        chk((wr_cnt - wr0) == ((kind == 4 && match) ? 1 : 0), tag, "write count",
            64'(wr_cnt - wr0), 64'((kind == 4 && match) ? 1 : 0));
        chk((rd_cnt - rd0) == ((kind == 4) ? 1 : 0), tag, "read count",
            64'(rd_cnt - rd0), 64'((kind == 4) ? 1 : 0));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bmem[i] = 64'h0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R10", "reset state",
            {61'd0, req_ready, mem_req, done}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R10", "after reset",
            {61'd0, req_ready, mem_req, done}, 64'b100);

        // R1: nothing to change
        run("R1", 64'h0000_0000_0000_0041, 1, 2'd0, 2'd0, 0, 1, 0, 1, 0, 64'h0);
        run("R1", 64'h0000_0000_0000_00C1, 2, 2'd1, 2'd0, 0, 1, 0, 1, 0, 64'h0);
        run("R1", 64'h0000_0000_0000_0041, 3, 2'd2, 2'd2, 0, 0, 0, 0, 0, 64'h0);
        // R3: successful updates with varying latency
        run("R3", 64'h0000_1234_0000_0001, 4, 2'd0, 2'd0, 0, 1, 0, 1, 0, 64'h0000_1234_0000_0001);
        run("R3", 64'h0000_5678_0000_000F, 5, 2'd1, 2'd0, 0, 1, 0, 1, 1, 64'h0000_5678_0000_000F);
        run("R3", 64'h0000_9ABC_0000_000B, 6, 2'd2, 2'd1, 0, 1, 0, 1, 3, 64'h0000_9ABC_0000_000B);
        run("R3", 64'h0000_0011_0000_0047, 7, 2'd1, 2'd0, 0, 1, 1, 1, 2, 64'h0000_0011_0000_0047);
        // R4: compare mismatch leaves memory alone
        run("R4", 64'h0000_2222_0000_0001, 8, 2'd1, 2'd0, 0, 1, 0, 1, 0, 64'h0000_2222_0000_0101);
        run("R4", 64'h0000_3333_0000_0001, 9, 2'd0, 2'd1, 0, 1, 0, 1, 4, 64'h0000_3333_0001_0001);
        // R6: updating disabled
        run("R6", 64'h0000_0000_0000_0001, 10, 2'd0, 2'd0, 0, 0, 1, 1, 0, 64'h1);
        run("R6", 64'h0000_0000_0000_0041, 10, 2'd1, 2'd1, 0, 0, 0, 1, 0, 64'h41);
        run("R6", 64'h0000_0000_0000_0001, 10, 2'd2, 2'd0, 0, 0, 0, 0, 0, 64'h1);
        // R2: stage enable selection
        run("R2", 64'h0000_0000_0000_0001, 11, 2'd0, 2'd2, 0, 0, 1, 1, 0, 64'h1);
        run("R2", 64'h0000_0000_0000_0001, 11, 2'd1, 2'd2, 0, 1, 0, 1, 0, 64'h1);
        run("R2", 64'h0000_0000_0000_0001, 11, 2'd1, 2'd2, 0, 1, 1, 1, 1, 64'h1);
        run("R2", 64'h0000_0000_0000_0001, 12, 2'd0, 2'd0, 0, 1, 0, 1, 0, 64'h1);
        run("R2", 64'h0000_0000_0000_0001, 12, 2'd2, 2'd1, 0, 1, 1, 1, 0, 64'h1);
        // R7: entry not writable
        run("R7", 64'h0000_0000_0000_0001, 13, 2'd0, 2'd0, 0, 1, 0, 0, 0, 64'h1);
        run("R7", 64'h0000_0000_0000_0041, 13, 2'd1, 2'd0, 0, 1, 0, 0, 0, 64'h41);
        run("R7", 64'h0000_0000_0000_0001, 13, 2'd2, 2'd2, 0, 1, 1, 0, 0, 64'h1);
        // R8: speculative accesses
        run("R8", 64'h0000_0000_0000_0041, 14, 2'd1, 2'd0, 1, 1, 0, 1, 0, 64'h41);
        run("R8", 64'h0000_0000_0000_0001, 14, 2'd1, 2'd0, 1, 1, 0, 1, 0, 64'h1);
        run("R8", 64'h0000_0000_0000_0001, 15, 2'd0, 2'd0, 1, 1, 0, 1, 1, 64'h1);
        // R5: long latency store update
        run("R5", 64'h0000_4444_0000_0003, 0, 2'd1, 2'd1, 0, 1, 0, 1, 6, 64'h0000_4444_0000_0003);

        repeat (2) @(negedge clk);
        finish_sim();
    end
endmodule